// File: doc/BRIEF.md
# Variable-Length Event Stream Decoder

This block sits on the receive side of a single data link. Each clock it may be offered one fixed-width frame. Frames flagged as not valid are idle filler. The valid frames form a continuous bit stream that carries events packed back to back. An event may begin or end anywhere inside a frame, and it may span several frames. Each event starts with a header that holds a 12-bit crossing identifier and, in most cases, an 8-bit count of the channels that were hit. The decoder reads the stream one item per cycle, either a whole header or one channel word. From the headers alone it works out where each event ends. The payload length is the hit count times a per-link channel width (`UNIT` bits).

The events leave the block as a strobed stream. A header cycle is marked with a start strobe and the crossing identifier. Each channel word follows on its own cycle, and the last word carries an end strobe. An event with no hits shows up as a single cycle that carries start, end and empty together. A parameter chooses between two header formats. In the fixed format every header is the same size. In the variable format the header is shorter when the event carries no data. The input has a ready signal because a payload can hold far fewer bits per word than a frame carries.

Top module: `vlf_decoder`

## Requirements
- R1: With `VAR_HDR=0` every header is 20 bits on the wire: the 12-bit crossing identifier first, then the 8-bit hit count. The most significant bit of each field arrives first, and bit `FRAME_W-1` of a frame is the first bit on the link.
- R2: After a header with hit count N, the next N×`UNIT` stream bits leave the block as N words of `UNIT` bits, one per cycle, each with `out_dvalid` high. They come in stream order, and the earliest bit of each word lands in its most significant bit.
- R3: Each header produces one cycle with `out_sop` high. From that cycle on, `out_bxid` shows the header's crossing identifier and holds it through every data word of the event.
- R4: `out_eop` rises on the last data word of an event, or on the header cycle when the event is empty, and at no other time. `out_sop` and `out_dvalid` are never high together.
- R5: A hit count of zero produces exactly one output cycle with `out_sop`, `out_eop` and `out_empty` all high, and no data words.
- R6: With `VAR_HDR=1` the header holds the 12-bit identifier and then a flag bit. If the flag is 0 the header ends there (13 bits) and the event is empty. If the flag is 1 the 8-bit hit count follows (21 bits in total). A count of zero after a set flag also gives an empty event.
- R7: A cycle with `in_valid` low adds no bits to the stream, whatever `in_data` holds.
- R8: A frame is taken only in a cycle where `in_valid` and `in_ready` are both high. A frame offered while `in_ready` is low is not taken. Frames that are taken are decoded with no bit lost or repeated, and events may straddle any number of frame boundaries.
- R9: While reset is held and after it is released, all output strobes are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame carries stream bits (low means idle) |
| in_data | input | FRAME_W | Link frame, bit FRAME_W-1 first |
| in_ready | output | 1 | Decoder has room for one more frame |
| out_sop | output | 1 | Header cycle of an event |
| out_dvalid | output | 1 | Channel word valid on out_data |
| out_eop | output | 1 | Final cycle of an event |
| out_empty | output | 1 | Event has no hit channels |
| out_bxid | output | 12 | Crossing identifier of the current event |
| out_data | output | UNIT | One channel word |

## Verification
The assertions assume that the input is a well-formed stream. After reset it has to begin on a header boundary, and every hit count has to be followed by its full payload. No cycle holds a stray end strobe, and the identifier must stay steady under data words. Both rules hold only when the decoder has never been fed a misaligned bit. The stimulus meets this by building every frame from a sequence of complete events. The only padding is zero bits added after the last event, and these parse as harmless empty events. Two instances, one for each header format, get randomly interleaved idle frames holding garbage. They are also offered frames while `in_ready` is low and must not take them.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int BX_W  = 12;
  localparam int CNT_W = 8;

  typedef enum logic {
    ST_HDR = 1'b0,
    ST_PAY = 1'b1
  } vlf_state_e;
endpackage

// File: rtl/vlf_bitacc.sv
// Left-aligned bit accumulator two frames wide. Consumed bits shift out
// at the top; an accepted frame is packed directly below the bits that remain.
module vlf_bitacc #(
  parameter int FW     = 32,
  parameter int ACC_W  = 2 * FW,
  parameter int FILL_W = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] take,
  input  logic              push,
  input  logic [FW-1:0]     push_data,
  output logic [ACC_W-1:0]  acc,
  output logic [FILL_W-1:0] fill,
  output logic              room
);
  logic [ACC_W-1:0]  acc_q, acc_nxt, ext;
  logic [FILL_W-1:0] fill_q, fill_nxt, fill_after;

  always_comb begin
    fill_after = fill_q - take;
    ext        = {push_data, {(ACC_W - FW){1'b0}}} >> fill_after;
    acc_nxt    = acc_q << take;
    fill_nxt   = fill_after;
    if (push) begin
      acc_nxt  = acc_nxt | ext;
      fill_nxt = fill_after + FILL_W'(FW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else begin
      acc_q  <= acc_nxt;
      fill_q <= fill_nxt;
    end
  end

  assign acc  = acc_q;
  assign fill = fill_q;
  assign room = (fill_after <= FILL_W'(FW));
endmodule

// File: rtl/vlf_item_parse.sv
// Looks at the top of the accumulator and reports whether a whole header
// or a whole channel word is present.
module vlf_item_parse
  import vlf_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int FILL_W  = 7,
  parameter int UNIT    = 4,
  parameter bit VAR_HDR = 1'b0
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [FILL_W-1:0] fill,
  output logic              hdr_ok,
  output logic [FILL_W-1:0] hdr_len,
  output logic [BX_W-1:0]   hdr_bx,
  output logic [CNT_W-1:0]  hdr_cnt,
  output logic              word_ok,
  output logic [UNIT-1:0]   word
);
  localparam int FIX_LEN   = BX_W + CNT_W;
  localparam int SHORT_LEN = BX_W + 1;
  localparam int LONG_LEN  = BX_W + 1 + CNT_W;

  assign hdr_bx  = acc[ACC_W-1 -: BX_W];
  assign word    = acc[ACC_W-1 -: UNIT];
  assign word_ok = (fill >= FILL_W'(UNIT));
  assign hdr_ok  = (fill >= hdr_len);

  generate
    if (VAR_HDR) begin : g_var
      logic has_data;
      assign has_data = acc[ACC_W-1-BX_W];
      assign hdr_len  = has_data ? FILL_W'(LONG_LEN) : FILL_W'(SHORT_LEN);
      assign hdr_cnt  = has_data ? acc[ACC_W-2-BX_W -: CNT_W] : '0;
    end else begin : g_fix
      assign hdr_len  = FILL_W'(FIX_LEN);
      assign hdr_cnt  = acc[ACC_W-1-BX_W -: CNT_W];
    end
  endgenerate
endmodule

// File: rtl/vlf_decoder.sv
module vlf_decoder
  import vlf_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int UNIT    = 4,
  parameter bit VAR_HDR = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_data,
  output logic               in_ready,
  output logic               out_sop,
  output logic               out_dvalid,
  output logic               out_eop,
  output logic               out_empty,
  output logic [11:0]        out_bxid,
  output logic [UNIT-1:0]    out_data
);
  localparam int ACC_W  = 2 * FRAME_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  if (UNIT < 4) begin : g_unit_too_small
    $error("vlf_decoder: UNIT must be at least 4");
  end
  if (UNIT > FRAME_W || FRAME_W < BX_W + CNT_W + 1) begin : g_frame_too_small
    $error("vlf_decoder: FRAME_W too small for header or channel word");
  end

  logic [ACC_W-1:0]  acc_w;
  logic [FILL_W-1:0] fill_w, take_w, hdr_len_w;
  logic              room_w, push_w, hdr_ok_w, word_ok_w;
  logic [BX_W-1:0]   hdr_bx_w;
  logic [CNT_W-1:0]  hdr_cnt_w;
  logic [UNIT-1:0]   word_w;

  vlf_state_e        st_q, st_nxt;
  logic [CNT_W-1:0]  rem_q, rem_nxt;
  logic              sop_q, dv_q, eop_q, emp_q;
  logic              sop_nxt, dv_nxt, eop_nxt, emp_nxt;
  logic [BX_W-1:0]   bx_q, bx_nxt;
  logic [UNIT-1:0]   data_q;

  assign push_w   = in_valid && room_w;
  assign in_ready = room_w;

  vlf_bitacc #(.FW(FRAME_W), .ACC_W(ACC_W), .FILL_W(FILL_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_w),
    .push      (push_w),
    .push_data (in_data),
    .acc       (acc_w),
    .fill      (fill_w),
    .room      (room_w)
  );

  vlf_item_parse #(.ACC_W(ACC_W), .FILL_W(FILL_W), .UNIT(UNIT), .VAR_HDR(VAR_HDR)) u_parse (
    .acc     (acc_w),
    .fill    (fill_w),
    .hdr_ok  (hdr_ok_w),
    .hdr_len (hdr_len_w),
    .hdr_bx  (hdr_bx_w),
    .hdr_cnt (hdr_cnt_w),
    .word_ok (word_ok_w),
    .word    (word_w)
  );

  // Next-state: one item (header or channel word) per cycle.
  always_comb begin
    st_nxt  = st_q;
    rem_nxt = rem_q;
    bx_nxt  = bx_q;
    take_w  = '0;
    sop_nxt = 1'b0;
    dv_nxt  = 1'b0;
    eop_nxt = 1'b0;
    emp_nxt = 1'b0;
    unique case (st_q)
      ST_HDR: begin
        if (hdr_ok_w) begin
          take_w  = hdr_len_w;
          sop_nxt = 1'b1;
          bx_nxt  = hdr_bx_w;
          if (hdr_cnt_w == '0) begin
            eop_nxt = 1'b1;
            emp_nxt = 1'b1;
          end else begin
            st_nxt  = ST_PAY;
            rem_nxt = hdr_cnt_w;
          end
        end
      end
      ST_PAY: begin
        if (word_ok_w) begin
          take_w  = FILL_W'(UNIT);
          dv_nxt  = 1'b1;
          rem_nxt = rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            eop_nxt = 1'b1;
            st_nxt  = ST_HDR;
          end
        end
      end
      default: st_nxt = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      rem_q  <= '0;
      sop_q  <= 1'b0;
      dv_q   <= 1'b0;
      eop_q  <= 1'b0;
      emp_q  <= 1'b0;
      bx_q   <= '0;
      data_q <= '0;
    end else begin
      st_q  <= st_nxt;
      rem_q <= rem_nxt;
      sop_q <= sop_nxt;
      dv_q  <= dv_nxt;
      eop_q <= eop_nxt;
      emp_q <= emp_nxt;
      bx_q  <= bx_nxt;
      if (dv_nxt) begin
        data_q <= word_w;
      end
    end
  end

  assign out_sop    = sop_q;
  assign out_dvalid = dv_q;
  assign out_eop    = eop_q;
  assign out_empty  = emp_q;
  assign out_bxid   = bx_q;
  assign out_data   = data_q;
endmodule

// File: rtl/vlf_decoder_chk.sv
module vlf_decoder_chk #(
  parameter int FRAME_W = 32,
  parameter int UNIT    = 4,
  localparam int ACC_W  = 2 * FRAME_W,
  localparam int FILL_W = $clog2(ACC_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_sop,
  input logic              out_dvalid,
  input logic              out_eop,
  input logic              out_empty,
  input logic [11:0]       out_bxid,
  input logic [FILL_W-1:0] acc_fill
);
  // R4
  sop_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sop && out_dvalid));

  // R4
  eop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_dvalid || out_empty));

  // R5
  empty_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_empty |-> (out_sop && out_eop && !out_dvalid));

  // R3
  bxid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dvalid |-> $stable(out_bxid));

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fill <= FILL_W'(ACC_W));

  // R8
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (acc_fill >= FILL_W'(FRAME_W)));
endmodule

bind vlf_decoder vlf_decoder_chk #(.FRAME_W(FRAME_W), .UNIT(UNIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_sop    (out_sop),
  .out_dvalid (out_dvalid),
  .out_eop    (out_eop),
  .out_empty  (out_empty),
  .out_bxid   (out_bxid),
  .acc_fill   (fill_w)
);

// File: tb/vlf_decoder_bench.sv
module vlf_decoder_bench;
  localparam int FW         = 32;
  localparam int UNIT       = 4;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic            is_sop;
    logic [11:0]     bx;
    logic            empty;
    logic [UNIT-1:0] word;
    logic            last;
  } tok_t;

  logic clk = 1'b0;
  logic rst_n;
  logic            vld [2];
  logic [FW-1:0]   dat [2];
  logic            rdy [2];
  logic            sop [2];
  logic            dv  [2];
  logic            eop [2];
  logic            emp [2];
  logic [11:0]     bx  [2];
  logic [UNIT-1:0] wd  [2];

  tok_t tokq  [2][$];
  bit   sendq [2][$];
  bit   bitq  [2][$];
  bit            in_hdr [2];
  int            rem    [2];
  logic [11:0]   curbx  [2];
  bit            hold   [2];
  logic [FW-1:0] hframe [2];

  int ntests = 0;
  int nfail  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vlf_decoder #(.FRAME_W(FW), .UNIT(UNIT), .VAR_HDR(1'b0)) u_vlf_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_data(dat[0]), .in_ready(rdy[0]),
    .out_sop(sop[0]), .out_dvalid(dv[0]), .out_eop(eop[0]), .out_empty(emp[0]),
    .out_bxid(bx[0]), .out_data(wd[0]));

  vlf_decoder #(.FRAME_W(FW), .UNIT(UNIT), .VAR_HDR(1'b1)) u_vlf_decoder_var (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_data(dat[1]), .in_ready(rdy[1]),
    .out_sop(sop[1]), .out_dvalid(dv[1]), .out_eop(eop[1]), .out_empty(emp[1]),
    .out_bxid(bx[1]), .out_data(wd[1]));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic append(input int m, input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) sendq[m].push_back(v[i]);
  endtask

  task automatic add_event(input int m, input logic [11:0] b, input int n);
    append(m, 32'(b), 12);
    if (m == 0) append(m, 32'(n), 8);
    else if (n == 0) append(m, 32'd0, 1);
    else begin
      append(m, 32'd1, 1);
      append(m, 32'(n), 8);
    end
    for (int k = 0; k < n; k++) append(m, $urandom, UNIT);
  endtask

  // Behavioural reference: greedy parse of the accepted bit queue.
  task automatic model_parse(input int m);
    while (1) begin
      if (in_hdr[m]) begin
        int need;
        int cnt;
        tok_t t;
        need = (m == 0) ? 20 : 13;
        if (m == 1 && bitq[m].size() >= 13 && bitq[m][12]) need = 21;
        if (bitq[m].size() < need) break;
        curbx[m] = '0;
        for (int i = 0; i < 12; i++) curbx[m] = {curbx[m][10:0], bitq[m].pop_front()};
        cnt = 0;
        if (m == 0) begin
          for (int i = 0; i < 8; i++) cnt = cnt * 2 + int'(bitq[m].pop_front());
        end else if (bitq[m].pop_front()) begin
          for (int i = 0; i < 8; i++) cnt = cnt * 2 + int'(bitq[m].pop_front());
        end
        t = '0;
        t.is_sop = 1'b1;
        t.bx     = curbx[m];
        t.empty  = (cnt == 0);
        tokq[m].push_back(t);
        if (cnt != 0) begin
          in_hdr[m] = 1'b0;
          rem[m]    = cnt;
        end
      end else begin
        tok_t t;
        if (bitq[m].size() < UNIT) break;
        t = '0;
        t.bx = curbx[m];
        for (int i = 0; i < UNIT; i++) t.word = {t.word[UNIT-2:0], bitq[m].pop_front()};
        rem[m]--;
        t.last = (rem[m] == 0);
        if (t.last) in_hdr[m] = 1'b1;
        tokq[m].push_back(t);
      end
    end
  endtask

  task automatic compare(input int m);
    tok_t t;
    string hreq;
    hreq = (m == 0) ? "R1" : "R6";
    if (sop[m] || dv[m]) begin
      if (tokq[m].size() == 0) begin
        check(1'b0, "R8", "output with nothing expected", 1, 0);
      end else begin
        t = tokq[m].pop_front();
        if (t.is_sop) begin
          check(sop[m] && !dv[m], hreq, "header strobe", {sop[m], dv[m]}, 2);
          check(bx[m] == t.bx, "R3", "crossing id at header", bx[m], t.bx);
          check(emp[m] == t.empty, "R5", "empty marker", emp[m], t.empty);
          check(eop[m] == t.empty, "R4", "eop on header", eop[m], t.empty);
        end else begin
          check(dv[m] && !sop[m], "R2", "data strobe", {sop[m], dv[m]}, 1);
          check(wd[m] == t.word, "R2", "channel word", wd[m], t.word);
          check(eop[m] == t.last, "R4", "eop on word", eop[m], t.last);
          check(bx[m] == t.bx, "R3", "crossing id held", bx[m], t.bx);
        end
      end
    end else if (eop[m] || emp[m]) begin
      check(1'b0, "R4", "stray eop/empty", {eop[m], emp[m]}, 0);
    end
  endtask

  function automatic logic [FW-1:0] next_frame(input int m);
    logic [FW-1:0] f;
    f = '0;
    for (int i = 0; i < FW; i++) begin
      f = {f[FW-2:0], (sendq[m].size() > 0) ? sendq[m].pop_front() : 1'b0};
    end
    return f;
  endfunction

  task automatic drive(input int m);
    int r;
    r = int'($urandom % 8);
    vld[m] = 1'b0;
    dat[m] = $urandom;
    if (!hold[m] && sendq[m].size() > 0) begin
      hframe[m] = next_frame(m);
      hold[m]   = 1'b1;
    end
    if (hold[m] && r != 0) begin
      if (rdy[m]) begin
        vld[m] = 1'b1;
        dat[m] = hframe[m];
        for (int i = FW - 1; i >= 0; i--) bitq[m].push_back(hframe[m][i]);
        model_parse(m);
        hold[m] = 1'b0;
      end else if (r == 1) begin
        // R8: offered while not ready, must not be taken
        vld[m] = 1'b1;
        dat[m] = hframe[m];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      ntests++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    int guard;
    int late;
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      vld[m] = 1'b0; dat[m] = '0; in_hdr[m] = 1'b1; rem[m] = 0;
      curbx[m] = '0; hold[m] = 1'b0; hframe[m] = '0;
    end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(!sop[m] && !dv[m] && !eop[m] && !emp[m], "R9", "strobes in reset",
            {sop[m], dv[m], eop[m], emp[m]}, 0);
      check(rdy[m] == 1'b1, "R9", "ready in reset", rdy[m], 1);
    end
    rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      add_event(m, 12'hABC, 10);   // R2: 10 hits x 4 bits = 40 bits
      add_event(m, 12'h001, 0);    // R5
      add_event(m, 12'h002, 0);    // R5 back to back
      add_event(m, 12'hFFF, 255);  // largest count
      add_event(m, 12'h123, 1);
      for (int k = 0; k < 60; k++) begin
        int n;
        n = (($urandom % 5) == 0) ? 0 : int'($urandom % 21);
        add_event(m, 12'($urandom), n);
      end
    end

    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(!sop[m] && !dv[m] && !eop[m], "R9", "strobes after release",
            {sop[m], dv[m], eop[m]}, 0);
    end

    while (sendq[0].size() > 0 || sendq[1].size() > 0 || hold[0] || hold[1]) begin
      for (int m = 0; m < 2; m++) compare(m);
      for (int m = 0; m < 2; m++) drive(m);
      @(negedge clk);
    end

    guard = 0;
    while ((tokq[0].size() > 0 || tokq[1].size() > 0) && guard < 20000) begin
      for (int m = 0; m < 2; m++) compare(m);
      for (int m = 0; m < 2; m++) begin vld[m] = 1'b0; dat[m] = $urandom; end
      guard++;
      @(negedge clk);
    end
    for (int m = 0; m < 2; m++) begin
      check(tokq[m].size() == 0, "R8", "all decoded items delivered", tokq[m].size(), 0);
    end

    // R7: idle frames with garbage must add nothing
    late = 0;
    repeat (100) begin
      for (int m = 0; m < 2; m++) begin
        compare(m);
        if (sop[m] || dv[m]) late++;
        vld[m] = 1'b0;
        dat[m] = $urandom;
      end
      @(negedge clk);
    end
    check(late == 0, "R7", "output during idle-only window", late, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule